// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides which interrupt the core services next. It takes five hardware request lines. Each line is qualified by its own trigger rule. The maskable lines are then gated by a global enable and, for three of them, by a per-line mask. The block picks the highest-priority request that survives this gating. It raises a request flag to the core and drives the 16-bit address of the service routine.

The core reports that it has taken the request with a one-cycle accept strobe. On accept, the block clears the pending state of the serviced line. It also clears the global enable, unless the serviced line is the non-maskable one. The lowest-priority line has no fixed address. When that line is accepted, the block raises an acknowledge and passes through an address supplied from outside.

The core's enable, disable and mask-write instructions arrive as simple strobes. A separate combinational path turns a software restart number into its fixed address, whatever the enable and mask state. An 8-bit status word exposes the masks, the enable and the pending state of the three vectored maskable lines.

Top module: `irq_vector_unit`

## Requirements
- R1: Priority from highest to lowest is `nmi_in`, `edge_in`, `lvl_hi_in`, `lvl_lo_in`, `ext_in`. When several eligible requests coexist, `irq_vec` shows the vector of the highest one.
- R2: A valid `nmi_in` request raises `irq_req` and selects vector 0x0024 whatever the global enable and the masks are.
- R3: `nmi_in` is valid only after a rising edge and only while the input stays high. A one-cycle pulse produces no request. After an accepted request, a line that stays high produces no new request until it falls and rises again.
- R4: A rising edge on `edge_in` sets a pending latch that holds after the input falls and holds while that line is masked. The latch clears when its request is accepted or on a mask write with `mask_cmd[3]`=1.
- R5: `lvl_hi_in`, `lvl_lo_in` and `ext_in` request only while high. Nothing is latched for them.
- R6: `en_set` sets the global enable and `en_clr` clears it. A mask write loads the masks from `mask_cmd[2:0]`: bit 0 masks `lvl_lo_in`, bit 1 masks `lvl_hi_in`, bit 2 masks `edge_in` (1 = masked). Disabled or masked maskable lines produce no `irq_req`.
- R7: Accepting any maskable request clears the global enable on the next cycle. Accepting the `nmi_in` request leaves it unchanged.
- R8: When `ext_in` is the selected request, `irq_vec` equals `ext_vec`. `ext_ack` is high exactly while `accept` is high with that line selected.
- R9: The fixed vectors are 0x003C for `edge_in`, 0x0034 for `lvl_hi_in` and 0x002C for `lvl_lo_in`. `irq_vec` is 0x0000 when `irq_req` is low.
- R10: `sw_vec` equals `sw_num`×8 (0x0000 to 0x0038) and depends on nothing else.
- R11: `status` = {0, pending `edge_in`, level `lvl_hi_in`, level `lvl_lo_in`, enable, masks[2:0]}. The pending bits are shown regardless of the masks.
- R12: After reset the enable is 0, all three masks are 1, no latch is pending, `irq_req` is 0 and `status` is 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge and level qualified |
| edge_in | input | 1 | Edge-latched maskable request |
| lvl_hi_in | input | 1 | Level maskable request, higher of the two |
| lvl_lo_in | input | 1 | Level maskable request, lower of the two |
| ext_in | input | 1 | Level request with externally supplied vector |
| en_set | input | 1 | Global enable set strobe |
| en_clr | input | 1 | Global enable clear strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_cmd | input | 4 | Mask write data: [2:0] masks, [3] clears edge latch |
| accept | input | 1 | Core takes the current request |
| ext_vec | input | 16 | Vector for the external-vector line |
| sw_num | input | 3 | Software restart number |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Service address of the selected request |
| ext_ack | output | 1 | Acknowledge for the external-vector line |
| sw_vec | output | 16 | Address for the software restart number |
| status | output | 8 | Masks, enable and pending state |

## Verification
The assertions assume that `accept` is pulsed for a single cycle and only while `irq_req` is high. They also assume that `en_set` and `en_clr` are never raised in the same cycle. The stimulus drives every strobe as a one-cycle pulse and raises `accept` only after a check has shown a request. It does not raise an edge on the latched line in the cycle of a latch-clearing mask write. All inputs change one nanosecond after a rising edge, so each edge sees stable request lines.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int VEC_W      = 16;
    localparam int SW_NUM_W   = 3;
    localparam int SW_STEP_LG = 3;
    localparam int MASK_N     = 3;
    localparam int CMD_W      = MASK_N + 1;
    localparam int STAT_W     = 8;

    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_EDGE,
        SRC_HI,
        SRC_LO,
        SRC_EXT
    } src_e;

    typedef struct packed {
        logic nmi;
        logic edg;
        logic hi;
        logic lo;
        logic ext;
    } req_t;

    function automatic logic [VEC_W-1:0] sw_vector(input logic [SW_NUM_W-1:0] n);
        logic [VEC_W-1:0] v;
        v = '0;
        v[SW_STEP_LG +: SW_NUM_W] = n;
        return v;
    endfunction

    function automatic logic is_maskable(input src_e s);
        return (s == SRC_EDGE) || (s == SRC_HI) || (s == SRC_LO) || (s == SRC_EXT);
    endfunction

endpackage

// File: rtl/irqv_trigger.sv
module irqv_trigger (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic edge_in,
    input  logic clr_nmi,
    input  logic clr_edge,
    output logic nmi_valid,
    output logic edge_pend
);

    logic nmi_q;
    logic edge_q;
    logic nmi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q     <= 1'b1;
            edge_q    <= 1'b1;
            nmi_pend  <= 1'b0;
            edge_pend <= 1'b0;
        end else begin
            nmi_q  <= nmi_in;
            edge_q <= edge_in;
            if (!nmi_in || clr_nmi)
                nmi_pend <= 1'b0;
            else if (!nmi_q)
                nmi_pend <= 1'b1;
            if (clr_edge)
                edge_pend <= 1'b0;
            else if (edge_in && !edge_q)
                edge_pend <= 1'b1;
        end
    end

    assign nmi_valid = nmi_pend && nmi_in;

    AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        edge_pend && !clr_edge |=> edge_pend); // R4

    AST_NMI_PRIOR_HIGH: assert property (@(posedge clk) disable iff (rst)
        nmi_valid |-> $past(nmi_in)); // R3

    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_pend) |-> $past(edge_in) && !$past(clr_edge)); // R4

endmodule

// File: rtl/irqv_mask_ctl.sv
module irqv_mask_ctl
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_wr,
    input  logic [CMD_W-1:0]  mask_cmd,
    input  logic              mask_taken,
    output logic              ien,
    output logic [MASK_N-1:0] mask,
    output logic              clr_edge_cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= 1'b0;
            mask <= '1;
        end else begin
            if (mask_taken || en_clr)
                ien <= 1'b0;
            else if (en_set)
                ien <= 1'b1;
            if (mask_wr)
                mask <= mask_cmd[MASK_N-1:0];
        end
    end

    assign clr_edge_cmd = mask_wr && mask_cmd[MASK_N];

    AST_TAKE_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
        mask_taken |=> !ien); // R7

    AST_EI_RAISES_EN: assert property (@(posedge clk) disable iff (rst)
        en_set && !en_clr && !mask_taken |=> ien); // R6

    AST_DI_LOWERS_EN: assert property (@(posedge clk) disable iff (rst)
        en_clr |=> !ien); // R6

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  req_t             req,
    input  logic [VEC_W-1:0] ext_vec,
    output src_e             sel,
    output logic             any,
    output logic [VEC_W-1:0] vec
);

    always_comb begin
        if (req.nmi)      sel = SRC_NMI;
        else if (req.edg) sel = SRC_EDGE;
        else if (req.hi)  sel = SRC_HI;
        else if (req.lo)  sel = SRC_LO;
        else if (req.ext) sel = SRC_EXT;
        else              sel = SRC_NONE;
    end

    always_comb begin
        case (sel)
            SRC_NMI:  vec = VEC_NMI;
            SRC_EDGE: vec = VEC_EDGE;
            SRC_HI:   vec = VEC_HI;
            SRC_LO:   vec = VEC_LO;
            SRC_EXT:  vec = ext_vec;
            default:  vec = '0;
        endcase
    end

    assign any = (sel != SRC_NONE);

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_in,
    input  logic                edge_in,
    input  logic                lvl_hi_in,
    input  logic                lvl_lo_in,
    input  logic                ext_in,
    input  logic                en_set,
    input  logic                en_clr,
    input  logic                mask_wr,
    input  logic [3:0]          mask_cmd,
    input  logic                accept,
    input  logic [15:0]         ext_vec,
    input  logic [2:0]          sw_num,
    output logic                irq_req,
    output logic [15:0]         irq_vec,
    output logic                ext_ack,
    output logic [15:0]         sw_vec,
    output logic [7:0]          status
);

    logic              nmi_valid;
    logic              edge_pend;
    logic              ien;
    logic [MASK_N-1:0] mask;
    logic              clr_edge_cmd;
    logic              taken;
    logic              mask_taken;
    req_t              elig;
    src_e              sel;

    assign taken      = accept && irq_req;
    assign mask_taken = taken && is_maskable(sel);

    irqv_trigger u_trig (
        .clk       (clk),
        .rst       (rst),
        .nmi_in    (nmi_in),
        .edge_in   (edge_in),
        .clr_nmi   (taken && (sel == SRC_NMI)),
        .clr_edge  (clr_edge_cmd || (taken && (sel == SRC_EDGE))),
        .nmi_valid (nmi_valid),
        .edge_pend (edge_pend)
    );

    irqv_mask_ctl u_mask (
        .clk          (clk),
        .rst          (rst),
        .en_set       (en_set),
        .en_clr       (en_clr),
        .mask_wr      (mask_wr),
        .mask_cmd     (mask_cmd),
        .mask_taken   (mask_taken),
        .ien          (ien),
        .mask         (mask),
        .clr_edge_cmd (clr_edge_cmd)
    );

    always_comb begin
        elig.nmi = nmi_valid;
        elig.edg = ien && edge_pend && !mask[2];
        elig.hi  = ien && lvl_hi_in && !mask[1];
        elig.lo  = ien && lvl_lo_in && !mask[0];
        elig.ext = ien && ext_in;
    end

    irqv_arbiter u_arb (
        .req     (elig),
        .ext_vec (ext_vec),
        .sel     (sel),
        .any     (irq_req),
        .vec     (irq_vec)
    );

    assign ext_ack = accept && (sel == SRC_EXT);
    assign sw_vec  = sw_vector(sw_num);
    assign status  = {1'b0, edge_pend, lvl_hi_in, lvl_lo_in, ien, mask};

    always_comb begin
        AST_SW_ALIGNED: assert (sw_vec[2:0] == 3'b000 && sw_vec[15:6] == '0); // R10
    end

    AST_ACK_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        ext_ack |-> accept && irq_vec == ext_vec); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !status[3] && !nmi_valid |-> !irq_req); // R6

    AST_NMI_ON_TOP: assert property (@(posedge clk) disable iff (rst)
        nmi_valid |-> irq_req && irq_vec == VEC_NMI); // R2

    AST_NMI_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        taken && irq_vec == VEC_NMI && nmi_valid && !en_set && !en_clr
        |=> status[3] == $past(status[3])); // R7

    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> irq_vec == '0); // R9

endmodule

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_in = 0, edge_in = 0, lvl_hi_in = 0, lvl_lo_in = 0, ext_in = 0;
    logic        en_set = 0, en_clr = 0, mask_wr = 0, accept = 0;
    logic [3:0]  mask_cmd = '0;
    logic [15:0] ext_vec = '0;
    logic [2:0]  sw_num = '0;
    logic        irq_req, ext_ack;
    logic [15:0] irq_vec, sw_vec;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic        req;
        logic [15:0] vec;
        logic        ack;
        logic [7:0]  st;
        logic [15:0] swv;
    } exp_t;

    exp_t sb[$];
    event smp;

    always #2 clk = ~clk;

    irq_vector_unit u0 (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .edge_in(edge_in),
        .lvl_hi_in(lvl_hi_in), .lvl_lo_in(lvl_lo_in), .ext_in(ext_in),
        .en_set(en_set), .en_clr(en_clr), .mask_wr(mask_wr), .mask_cmd(mask_cmd),
        .accept(accept), .ext_vec(ext_vec), .sw_num(sw_num),
        .irq_req(irq_req), .irq_vec(irq_vec), .ext_ack(ext_ack),
        .sw_vec(sw_vec), .status(status)
    );

    initial begin
        forever begin
            @(smp);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (irq_req !== e.req || irq_vec !== e.vec || ext_ack !== e.ack ||
                    status !== e.st || sw_vec !== e.swv) begin
                    fails++;
                    $display("FAIL %s: req/vec/ack/st/sw got %b/%h/%b/%h/%h exp %b/%h/%b/%h/%h",
                             e.tag, irq_req, irq_vec, ext_ack, status, sw_vec,
                             e.req, e.vec, e.ack, e.st, e.swv);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic req, input logic [15:0] vec,
                       input logic ack, input logic [7:0] st);
        exp_t e;
        e.tag = tag; e.req = req; e.vec = vec; e.ack = ack; e.st = st;
        e.swv = {10'b0, sw_num, 3'b000};
        #0;
        sb.push_back(e);
        ->smp;
        #0;
    endtask

    task automatic pulse_ei();  en_set = 1; tick(); en_set = 0; endtask
    task automatic pulse_di();  en_clr = 1; tick(); en_clr = 0; endtask
    task automatic wr_mask(input logic [3:0] c);
        mask_cmd = c; mask_wr = 1; tick(); mask_wr = 0; mask_cmd = '0;
    endtask
    task automatic edge_pulse(); edge_in = 1; tick(); edge_in = 0; tick(); endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R12 reset state", 0, 16'h0000, 0, 8'h07);

        pulse_ei();
        chk("R6 enable set", 0, 16'h0000, 0, 8'h0F);

        lvl_lo_in = 1; tick();
        chk("R6 masked level line quiet", 0, 16'h0000, 0, 8'h1F);

        wr_mask(4'h0);
        chk("R9 low level vector", 1, 16'h002C, 0, 8'h18);

        lvl_hi_in = 1; tick();
        chk("R1 high level over low", 1, 16'h0034, 0, 8'h38);

        edge_pulse();
        chk("R4 edge latched after pulse", 1, 16'h003C, 0, 8'h78);

        ext_in = 1; ext_vec = 16'h1234; tick();
        chk("R1 edge over ext line", 1, 16'h003C, 0, 8'h78);

        accept = 1;
        chk("R8 no ack for fixed line", 1, 16'h003C, 0, 8'h78);
        tick(); accept = 0;
        chk("R7 enable dropped and R4 latch cleared", 0, 16'h0000, 0, 8'h30);

        pulse_ei();
        chk("R5 high level still requests", 1, 16'h0034, 0, 8'h38);

        lvl_hi_in = 0; lvl_lo_in = 0; tick();
        chk("R8 external vector passed", 1, 16'h1234, 0, 8'h08);

        accept = 1;
        chk("R8 ack during accept", 1, 16'h1234, 1, 8'h08);
        tick(); accept = 0;
        chk("R7 ext accept drops enable", 0, 16'h0000, 0, 8'h00);

        ext_in = 0;
        pulse_ei();
        wr_mask(4'h7);
        chk("R6 all masked", 0, 16'h0000, 0, 8'h0F);

        nmi_in = 1; tick();
        chk("R2 nmi ignores masks", 1, 16'h0024, 0, 8'h0F);
        accept = 1;
        chk("R8 no ack for nmi", 1, 16'h0024, 0, 8'h0F);
        tick(); accept = 0;
        chk("R7 nmi keeps enable R3 no repeat while high", 0, 16'h0000, 0, 8'h0F);

        nmi_in = 0; tick();
        nmi_in = 1; tick(); nmi_in = 0;
        chk("R3 short nmi pulse ignored", 0, 16'h0000, 0, 8'h0F);
        tick();
        chk("R3 short nmi pulse still ignored", 0, 16'h0000, 0, 8'h0F);

        pulse_di();
        nmi_in = 1; tick();
        chk("R2 nmi with enable off", 1, 16'h0024, 0, 8'h07);
        accept = 1; tick(); accept = 0; nmi_in = 0; tick();
        chk("R7 enable stays off after nmi", 0, 16'h0000, 0, 8'h07);

        wr_mask(4'h0);
        lvl_lo_in = 1; tick();
        chk("R6 disabled level line quiet", 0, 16'h0000, 0, 8'h10);
        lvl_lo_in = 0; tick();
        chk("R5 level released", 0, 16'h0000, 0, 8'h00);

        pulse_ei();
        wr_mask(4'h4);
        edge_pulse();
        chk("R4 latch held while masked", 0, 16'h0000, 0, 8'h4C);
        wr_mask(4'h0);
        chk("R4 unmasked latch requests", 1, 16'h003C, 0, 8'h48);
        wr_mask(4'h8);
        chk("R4 mask write clears latch", 0, 16'h0000, 0, 8'h08);

        for (int n = 0; n < 8; n++) begin
            sw_num = n[2:0];
            chk("R10 software vector", 0, 16'h0000, 0, 8'h08);
        end
        sw_num = 3'd5;
        chk("R11 status unchanged by software number", 0, 16'h0000, 0, 8'h08);

        nmi_in = 1; edge_in = 1; lvl_hi_in = 1; lvl_lo_in = 1; ext_in = 1;
        tick();
        chk("R1 nmi highest", 1, 16'h0024, 0, 8'h78);
        accept = 1; tick(); accept = 0;
        chk("R1 edge next after nmi", 1, 16'h003C, 0, 8'h78);
        accept = 1; tick(); accept = 0;
        chk("R7 R4 edge accepted", 0, 16'h0000, 0, 8'h30);

        nmi_in = 0; edge_in = 0; lvl_hi_in = 0; lvl_lo_in = 0; ext_in = 0;
        tick();
        chk("R11 idle status", 0, 16'h0000, 0, 8'h00);

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule